// File: doc/BRIEF.md
# SONET Framing Pattern Detector

This block watches one deinterleaved lane of a bit-interleaved serial link and locates the framing word that opens each SONET frame. The lane arrives one bit at a time, qualified by a valid strobe. The detector slides a 32-bit window over the valid bits and compares it against two A1 bytes followed by two A2 bytes. A three-state controller walks from searching, through a single confirmation, to locked. While it is searching and no framing word turns up within a programmable number of valid bits, it issues a one-cycle roll request. The upstream demultiplexer uses that request to rotate its lane assignment, and the search then continues.

A framing word seen while searching starts a frame position counter. Lock is declared only when a second framing word ends exactly one frame length later. While locked, the detector checks every frame boundary. Four misses in a row drop it back to searching, and a good frame clears the miss count. The lock indication leaves the block as an active-low loss-of-frame flag, which is high while locked. A synchronous active-low frame reset returns the controller to searching from any state.

Top module: `sfd_frame_detector`

## Requirements
- R1: While rst_ni is low, state_o is 0, lof_no is 0 and roll_o is 0.
- R2: The framing word is 0xF6, 0xF6, 0x28, 0x28, received most significant bit first. Only cycles with bit_vld_i high shift the window or advance any count. A word with any bit different is not recognised.
- R3: In the search state (state_o = 0), a valid bit that completes the framing word moves state_o to the confirm state (1) on the next cycle. That bit becomes the frame position origin.
- R4: In the search state, after TIMEOUT_BITS valid bits with no framing word, roll_o is high for exactly one cycle and the search continues with a fresh count. roll_o is never high outside the search state.
- R5: In the confirm state, a framing word that ends exactly FRAME_BYTES*8 valid bits after the origin moves state_o to locked (2), and lof_no goes high on the same cycle.
- R6: In the confirm state, a missing framing word at that boundary returns state_o to 0. Framing words that end at any other position are ignored.
- R7: In the locked state every frame boundary is checked. MISS_LIMIT (4) consecutive misses return state_o to 0 and lof_no low. A good frame after fewer misses clears the miss count.
- R8: While frame_rst_ni is low, the next cycle shows state_o 0, lof_no 0 and roll_o 0. Bits presented during that time are discarded and the window is emptied.
- R9: state_o encodes search as 0, confirm as 1 and locked as 2, and lof_no is high only in state 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Lane clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_rst_ni | input | 1 | Synchronous frame reset, active low |
| bit_i | input | 1 | Lane data bit |
| bit_vld_i | input | 1 | Qualifies bit_i |
| roll_o | output | 1 | One-cycle request to rotate the demultiplexer |
| lof_no | output | 1 | Loss of frame, active low (high while locked) |
| state_o | output | 2 | Controller state: 0 search, 1 confirm, 2 locked |

## Verification
Faults in the frame position counter show up one frame later. A shifted origin makes a good second framing word land off the boundary, and state_o then falls to 0 at the end of the frame instead of moving to 2. A miss counter that saturates wrongly or fails to clear moves the drop from locked by whole frames, so lof_no falls a frame early or late. An error in the search timer shows as a roll_o pulse one or more valid bits away from the multiple of TIMEOUT_BITS where it belongs. The reference model compares all three outputs on every cycle, so each of these faults is reported in the cycle where it first reaches a port.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } sfd_state_e;
endpackage

// File: rtl/sfd_window.sv
module sfd_window #(
  parameter logic [7:0] A1  = 8'hF6,
  parameter logic [7:0] A2  = 8'h28,
  parameter int         REP = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic vld_i,
  input  logic bit_i,
  output logic hit_o
);
  localparam int NB = 2 * REP;
  localparam int W  = 8 * NB;

  logic [W-1:0] pat;
  logic [W-1:0] win_q;
  logic [W-1:0] win_nxt;

  for (genvar g = 0; g < NB; g++) begin : g_pat
    if (g < REP) begin : g_a1
      assign pat[W-1-8*g -: 8] = A1;
    end else begin : g_a2
      assign pat[W-1-8*g -: 8] = A2;
    end
  end

  assign win_nxt = {win_q[W-2:0], bit_i};
  assign hit_o   = vld_i && (win_nxt == pat);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    win_q <= '0;
    else if (clr_i) win_q <= '0;
    else if (vld_i) win_q <= win_nxt;
  end

  AST_WIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !clr_i) |=> $stable(win_q)); // R2
endmodule

// File: rtl/sfd_pos_counter.sv
module sfd_pos_counter #(
  parameter int FRAME_BITS = 77760
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic restart_i,
  input  logic step_i,
  output logic boundary_o
);
  localparam int PW = $clog2(FRAME_BITS);

  logic [PW-1:0] pos_q;

  assign boundary_o = step_i && (pos_q == PW'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pos_q <= '0;
    else if (clr_i || restart_i)    pos_q <= '0;
    else if (boundary_o)            pos_q <= '0;
    else if (step_i)                pos_q <= pos_q + 1'b1;
  end

  AST_POS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q < PW'(FRAME_BITS)); // R5
endmodule

// File: rtl/sfd_search_timer.sv
module sfd_search_timer #(
  parameter int TIMEOUT = 155520
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic expire_o
);
  localparam int TW = $clog2(TIMEOUT);

  logic [TW-1:0] cnt_q;

  assign expire_o = step_i && (cnt_q == TW'(TIMEOUT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (expire_o)  cnt_q <= '0;
    else if (step_i)    cnt_q <= cnt_q + 1'b1;
  end

  AST_TMR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < TW'(TIMEOUT)); // R4
endmodule

// File: rtl/sfd_frame_detector.sv
module sfd_frame_detector
  import sfd_pkg::*;
#(
  parameter int         FRAME_BYTES  = 9720,
  parameter int         TIMEOUT_BITS = 155520,
  parameter int         MISS_LIMIT   = 4,
  parameter logic [7:0] A1           = 8'hF6,
  parameter logic [7:0] A2           = 8'h28,
  parameter int         REP          = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_rst_ni,
  input  logic       bit_i,
  input  logic       bit_vld_i,
  output logic       roll_o,
  output logic       lof_no,
  output logic [1:0] state_o
);
  localparam int FRAME_BITS = FRAME_BYTES * 8;
  localparam int MW         = $clog2(MISS_LIMIT);

  sfd_state_e    state_q, state_d;
  logic [MW-1:0] miss_q, miss_d;
  logic          roll_q, roll_d;
  logic          vld_eff, hit, bnd, expire, in_search;

  assign vld_eff   = bit_vld_i && frame_rst_ni;
  assign in_search = (state_q == ST_SEARCH);

  sfd_window #(.A1(A1), .A2(A2), .REP(REP)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!frame_rst_ni),
    .vld_i  (vld_eff),
    .bit_i  (bit_i),
    .hit_o  (hit)
  );

  sfd_pos_counter #(.FRAME_BITS(FRAME_BITS)) u_pos (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (!frame_rst_ni),
    .restart_i  (hit && in_search),
    .step_i     (vld_eff),
    .boundary_o (bnd)
  );

  sfd_search_timer #(.TIMEOUT(TIMEOUT_BITS)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!frame_rst_ni || !in_search || hit),
    .step_i   (vld_eff && in_search),
    .expire_o (expire)
  );

  always_comb begin
    state_d = state_q;
    miss_d  = miss_q;
    roll_d  = 1'b0;
    if (!frame_rst_ni) begin
      state_d = ST_SEARCH;
      miss_d  = '0;
    end else begin
      unique case (state_q)
        ST_SEARCH: begin
          if (hit)         state_d = ST_CONFIRM;
          else if (expire) roll_d  = 1'b1;
        end
        ST_CONFIRM: begin
          if (bnd) begin
            state_d = hit ? ST_LOCKED : ST_SEARCH;
            miss_d  = '0;
          end
        end
        ST_LOCKED: begin
          if (bnd) begin
            if (hit) begin
              miss_d = '0;
            end else if (miss_q == MW'(MISS_LIMIT - 1)) begin
              state_d = ST_SEARCH;
              miss_d  = '0;
            end else begin
              miss_d = miss_q + 1'b1;
            end
          end
        end
        default: state_d = ST_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SEARCH;
      miss_q  <= '0;
      roll_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      miss_q  <= miss_d;
      roll_q  <= roll_d;
    end
  end

  assign roll_o  = roll_q;
  assign lof_no  = (state_q == ST_LOCKED);
  assign state_o = state_q;

  AST_ROLL_IN_SEARCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roll_q |-> state_q == ST_SEARCH); // R4
  AST_LOCK_VIA_CONFIRM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_LOCKED) |-> $past(state_q) == ST_CONFIRM); // R5
  AST_DROP_AFTER_MISSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_LOCKED && state_q == ST_SEARCH && $past(frame_rst_ni))
      |-> $past(miss_q) == MW'(MISS_LIMIT - 1)); // R7
  AST_FRAME_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_rst_ni |=> (state_q == ST_SEARCH && !roll_q)); // R8
endmodule

// File: tb/sim_sfd_frame_detector.sv
module sim_sfd_frame_detector;
  localparam int FB    = 12;
  localparam int FBITS = FB * 8;
  localparam int TO    = 200;
  localparam logic [31:0] PAT  = 32'hF6F62828;
  localparam logic [31:0] FILL = 32'h55AA55AA;

  logic clk = 1'b0, rst_n = 1'b0, frst_n = 1'b1, b = 1'b0, v = 1'b0;
  logic roll, lof_n;
  logic [1:0] st;

  always #2.5 clk = ~clk;

  sfd_frame_detector #(.FRAME_BYTES(FB), .TIMEOUT_BITS(TO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_rst_ni(frst_n), .bit_i(b),
    .bit_vld_i(v), .roll_o(roll), .lof_no(lof_n), .state_o(st)
  );

  int checks = 0, errors = 0, cycles = 0, rolls_seen = 0, gap_ctr = 0;

  // reference model
  int m_state = 0, m_pos = 0, m_tmr = 0, m_miss = 0;
  bit m_roll = 1'b0;
  bit m_win[$];

  function automatic bit m_hit();
    logic [31:0] w;
    if (m_win.size() < 32) return 1'b0;
    for (int i = 0; i < 32; i++) w[31-i] = m_win[i];
    return w == PAT;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_pos = 0; m_tmr = 0; m_miss = 0; m_roll = 0;
      m_win.delete();
    end else if (!frst_n) begin
      m_state = 0; m_pos = 0; m_tmr = 0; m_miss = 0; m_roll = 0;
      m_win.delete();
    end else begin
      m_roll = 0;
      if (v) begin
        bit hit, bnd;
        m_win.push_back(b);
        if (m_win.size() > 32) void'(m_win.pop_front());
        hit = m_hit();
        bnd = (m_pos == FBITS - 1);
        if (m_state == 0 && hit) m_pos = 0;
        else m_pos = bnd ? 0 : m_pos + 1;
        case (m_state)
          0: begin
            if (hit) begin m_state = 1; m_tmr = 0; end
            else if (m_tmr == TO - 1) begin m_roll = 1; m_tmr = 0; end
            else m_tmr++;
          end
          1: if (bnd) begin
            m_state = hit ? 2 : 0; m_miss = 0; m_tmr = 0;
          end
          default: if (bnd) begin
            if (hit) m_miss = 0;
            else if (m_miss == 3) begin m_state = 0; m_miss = 0; m_tmr = 0; end
            else m_miss++;
          end
        endcase
      end
    end
  end

  // per-cycle comparison and watchdog
  always @(negedge clk) begin
    cycles++;
    if (roll) rolls_seen++;
    if (rst_n) begin
      checks++;
      if (st != 2'(m_state)) begin
        errors++;
        $display("FAIL R9 state act=%0d exp=%0d t=%0t", st, m_state, $time);
      end else if (lof_n != (m_state == 2)) begin
        errors++;
        $display("FAIL R7 lof_no act=%0d exp=%0d t=%0t", lof_n, m_state == 2, $time);
      end else if (roll != m_roll) begin
        errors++;
        $display("FAIL R4 roll act=%0d exp=%0d t=%0t", roll, m_roll, $time);
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic x, input bit gaps);
    if (gaps && (gap_ctr++ % 3 == 2)) begin
      v = 1'b0; @(negedge clk);
    end
    b = x; v = 1'b1;
    @(negedge clk);
    v = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w, input int n, input bit gaps);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i], gaps);
  endtask

  task automatic good_frame(input bit gaps);
    send_word(FILL, 32, gaps); send_word(FILL, 32, gaps); send_word(PAT, 32, gaps);
  endtask

  task automatic bad_frame();
    send_word(FILL, 32, 0); send_word(FILL, 32, 0); send_word(FILL, 32, 0);
  endtask

  task automatic frame_reset();
    frst_n = 1'b0; @(negedge clk); frst_n = 1'b1; @(negedge clk);
  endtask

  initial begin
    int r0;
    @(negedge clk); @(negedge clk);
    chk(st == 0 && lof_n == 0 && roll == 0, "R1 reset outputs", st, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: no framing word for 450 valid bits -> two rolls, still searching
    r0 = rolls_seen;
    for (int i = 0; i < 450; i++) send_bit(1'b0, 0);
    chk(rolls_seen - r0 == 2, "R4 roll count", rolls_seen - r0, 2);
    chk(st == 0, "R4 keeps searching", st, 0);

    // R3 / R5: first word -> confirm, second at boundary -> locked
    send_word(PAT, 32, 0);
    chk(st == 1, "R3 confirm after first word", st, 1);
    good_frame(0);
    chk(st == 2 && lof_n == 1, "R5 locked", st, 2);

    // R7: three misses then good frame clears, four misses drop
    for (int i = 0; i < 3; i++) bad_frame();
    chk(st == 2, "R7 three misses hold lock", st, 2);
    good_frame(0);
    for (int i = 0; i < 3; i++) bad_frame();
    chk(st == 2, "R7 miss count cleared", st, 2);
    bad_frame();
    chk(st == 0 && lof_n == 0, "R7 fourth miss drops", st, 0);

    // R6: miss at confirm boundary
    frame_reset();
    send_word(PAT, 32, 0);
    bad_frame();
    chk(st == 0, "R6 confirm miss", st, 0);

    // R6: off-position word ignored, correct one locks
    frame_reset();
    send_word(PAT, 32, 0);
    send_word(FILL, 16, 0);
    send_word(PAT, 32, 0);
    chk(st == 1, "R6 off position ignored", st, 1);
    send_word(FILL, 16, 0);
    send_word(PAT, 32, 0);
    chk(st == 2, "R6 lock at true boundary", st, 2);

    // R8: frame reset while locked, bits discarded
    frst_n = 1'b0;
    send_word(PAT, 32, 0);
    chk(st == 0 && lof_n == 0 && roll == 0, "R8 frame reset forces search", st, 0);
    send_word(PAT, 16, 0);
    frst_n = 1'b1;
    send_word(PAT, 16, 0);
    chk(st == 0, "R8 bits during reset discarded", st, 0);

    // R2: corrupted word not recognised
    frame_reset();
    send_word(32'hF6F72828, 32, 0);
    chk(st == 0, "R2 corrupted word", st, 0);

    // R2: gaps in valid strobe do not disturb framing
    frame_reset();
    send_word(PAT, 32, 1);
    chk(st == 1, "R2 gapped first word", st, 1);
    good_frame(1);
    chk(st == 2 && lof_n == 1, "R2 gapped lock", st, 2);

    // R1: asynchronous reset from locked
    rst_n = 1'b0;
    @(negedge clk);
    chk(st == 0 && lof_n == 0 && roll == 0, "R1 reset from locked", st, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule